// File: doc/BRIEF.md
# HDLC Frame Receiver with Per-Read Packet Status

This block takes a bit-serial HDLC line, one bit per cycle in which `bit_valid` is high, least significant bit of each octet first. It finds the opening and closing flags, discards the zero that a transmitter inserts after five ones, and packs the remaining bits into octets. It checks the frame check sequence and writes the payload octets into a small receive FIFO. The two check octets are removed before they reach the FIFO, so the block holds back the three most recent octets of the frame until it knows which of them are payload.

The host drains the FIFO one octet per `rd_en` pulse. Each read updates `rd_data` together with a 3-bit end-of-packet code. The code is zero for every octet except the last one stored for a frame, which carries the way that frame ended. `rd_empty` and `next_is_first` are live and describe the octet waiting at the head of the FIFO.

When the FIFO has no room, reception stops and the frame ends with an overrun code. The block then ignores the line until that code has been stored and a new flag arrives.

Top module: `hdlc_rx_status`

## Requirements
- R1: The flag 0x7E opens and closes frames. Back-to-back flags, and runs of idle ones between frames, store nothing in the FIFO.
- R2: A 0 that follows five consecutive 1s inside a frame is dropped before octet assembly, so payload octets such as 0x7E, 0xFF and 0x3F come back unchanged.
- R3: For a frame of four or more octets with a good check sequence, the payload octets come back in order with the two check octets removed. The check is CRC-16 with polynomial x^16+x^12+x^5+1, preset 0xFFFF, processed LSB first, and the residue over payload plus check octets must be 0xF0B8. The last payload octet reads with code 3'b001.
- R4: A frame that closes with a flag but whose residue is not 0xF0B8, or whose bit count is not a whole number of octets, gives code 3'b010 on its last stored octet.
- R5: A seventh consecutive 1 aborts the frame. If the frame had at least one complete octet, one final entry is stored with code 3'b011. This entry carries the oldest octet still held back, which is the third octet from the end.
- R6: If an entry must be stored while the FIFO is full, that octet is kept aside and reception stops. The kept octet is stored with code 3'b100 as soon as a slot frees. Line input is then ignored until the next flag after that store.
- R7: A closed frame of one to three octets, check octets included, stores exactly one entry: its first octet, with code 3'b101 and the first-octet mark.
- R8: `rd_status` is 3'b000 after reset and for every non-final octet. It changes only on a read of a non-empty FIFO and shows the code of the octet just read.
- R9: `rd_empty` is high after reset and whenever the FIFO holds no entry.
- R10: `next_is_first` is high exactly when the FIFO is not empty and its head octet is the first stored octet of a frame.
- R11: A read while the FIFO is empty leaves `rd_data` and `rd_status` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bit_valid | input | 1 | A line bit is present on `bit_in` this cycle |
| bit_in | input | 1 | Serial line bit |
| rd_en | input | 1 | Pop one octet from the receive FIFO |
| rd_data | output | 8 | Octet returned by the most recent read |
| rd_status | output | 3 | End-of-packet code of the most recent read |
| rd_empty | output | 1 | Receive FIFO holds no entry |
| next_is_first | output | 1 | Head octet opens a new message |

## Verification
The good-frame path is swept over payload lengths of two to four octets. The octets are drawn from a set that contains 0x7E, 0xFF and 0x3F, so that stuffed zeros land at many bit offsets. Any slip in destuffing or octet alignment shows up as a wrong octet or a bad check code. Frames that differ from a good one in only one respect then separate the end codes from one another: an altered check octet, a one-octet payload, a two-octet raw frame, a seven-ones abort and a frame longer than the FIFO. Flag-only and idle-ones stretches confirm that nothing is stored, and a read on an empty FIFO confirms that the last status is held.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   typedef enum logic [2:0] {
      PS_BUSY    = 3'b000,
      PS_GOOD    = 3'b001,
      PS_BADCRC  = 3'b010,
      PS_ABORT   = 3'b011,
      PS_OVERRUN = 3'b100,
      PS_SHORT   = 3'b101
   } pkt_stat_e;

   typedef struct packed {
      logic      first;
      pkt_stat_e stat;
      logic [7:0] data;
   } rx_entry_t;

   // reflected CRC update over one octet, LSB first
   function automatic logic [15:0] crc16_octet(input logic [15:0] c,
                                               input logic [7:0]  d,
                                               input logic [15:0] poly_rev);
      logic [15:0] r;
      r = c;
      for (int i = 0; i < 8; i++) begin
         if (r[0] ^ d[i]) r = (r >> 1) ^ poly_rev;
         else             r = r >> 1;
      end
      return r;
   endfunction

endpackage

// File: rtl/hdlc_bit_front.sv
module hdlc_bit_front #(
   parameter int FLAG_RUN  = 6,
   parameter int ABORT_RUN = 7
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid,
   input  logic bit_in,
   output logic ev_flag,
   output logic ev_abort,
   output logic ev_data,
   output logic data_bit
);
   localparam int CW = $clog2(ABORT_RUN + 1);
   localparam logic [CW-1:0] FLAG_CNT  = CW'(FLAG_RUN);
   localparam logic [CW-1:0] STUFF_CNT = CW'(FLAG_RUN - 1);
   localparam logic [CW-1:0] ABORT_CNT = CW'(ABORT_RUN - 1);
   localparam logic [CW-1:0] SAT_CNT   = CW'(ABORT_RUN);

   if (FLAG_RUN < 2 || ABORT_RUN <= FLAG_RUN) begin : g_bad_runs
      $error("hdlc_bit_front: need 2 <= FLAG_RUN < ABORT_RUN");
   end

   logic [CW-1:0] ones_q;
   logic          stuffed;

   always_comb begin
      ev_flag  = bit_valid && !bit_in && (ones_q == FLAG_CNT);
      stuffed  = bit_valid && !bit_in && (ones_q == STUFF_CNT);
      ev_abort = bit_valid &&  bit_in && (ones_q == ABORT_CNT);
      ev_data  = bit_valid && !ev_flag && !ev_abort && !stuffed;
      data_bit = bit_in;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ones_q <= '0;
      end else if (bit_valid) begin
         if (!bit_in)                ones_q <= '0;
         else if (ones_q != SAT_CNT) ones_q <= ones_q + CW'(1);
      end
   end

   // R2: a line bit is at most one of flag end, abort or payload bit
   a_r2_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({ev_flag, ev_abort, ev_data}));

   // R1: the bit after a flag starts a fresh run of ones
   a_r1_flag_resets_run: assert property (@(posedge clk) disable iff (!rst_n)
      ev_flag |=> (ones_q == '0));

endmodule

// File: rtl/hdlc_frame_asm.sv
module hdlc_frame_asm
   import hdlc_rx_pkg::*;
#(
   parameter int          FCS_BYTES    = 2,
   parameter int          MIN_OK_BYTES = 4,
   parameter logic [15:0] CRC_INIT     = 16'hFFFF,
   parameter logic [15:0] CRC_POLY_REV = 16'h8408,
   parameter logic [15:0] CRC_RESIDUE  = 16'hF0B8
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      ev_flag,
   input  logic      ev_abort,
   input  logic      ev_data,
   input  logic      data_bit,
   input  logic      fifo_full,
   output logic      push,
   output rx_entry_t push_entry
);
   localparam int HOLD = FCS_BYTES + 1;
   localparam int HW   = $clog2(HOLD + 1);
   localparam int TW   = $clog2(MIN_OK_BYTES + 1);
   localparam logic [HW-1:0] HOLD_FULL = HW'(HOLD);
   localparam logic [TW-1:0] TOT_SAT   = TW'(MIN_OK_BYTES);

   if (FCS_BYTES < 1 || MIN_OK_BYTES <= FCS_BYTES) begin : g_bad_len
      $error("hdlc_frame_asm: need 1 <= FCS_BYTES < MIN_OK_BYTES");
   end

   logic            open_q;
   logic [2:0]      bitcnt_q;
   logic [7:0]      sr_q;
   logic [15:0]     crc_q;
   logic [TW-1:0]   total_q;
   logic [HW-1:0]   hcnt_q;
   logic [7:0]      hold_q [HOLD];
   logic            pushed_q;
   logic            pend_q;
   rx_entry_t       pend_q_entry;

   logic            byte_done, spill, close_ev, abort_end, cand_valid, overflow;
   logic [7:0]      new_byte;
   rx_entry_t       cand;

   always_comb begin
      new_byte   = {data_bit, sr_q[7:1]};
      byte_done  = open_q && ev_data && (bitcnt_q == 3'd7);
      spill      = byte_done && (hcnt_q == HOLD_FULL);
      close_ev   = open_q && ev_flag  && (total_q != '0);
      abort_end  = open_q && ev_abort && (total_q != '0);
      cand_valid = spill || close_ev || abort_end;
      overflow   = cand_valid && fifo_full;

      cand.first = !pushed_q;
      cand.data  = hold_q[0];
      if (spill)                                   cand.stat = PS_BUSY;
      else if (abort_end)                          cand.stat = PS_ABORT;
      else if (total_q < TOT_SAT)                  cand.stat = PS_SHORT;
      else if (bitcnt_q != 3'd7 || crc_q != CRC_RESIDUE) cand.stat = PS_BADCRC;
      else                                         cand.stat = PS_GOOD;

      push       = !fifo_full && (cand_valid || pend_q);
      push_entry = pend_q ? pend_q_entry : cand;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q       <= 1'b0;
         bitcnt_q     <= '0;
         sr_q         <= '0;
         crc_q        <= CRC_INIT;
         total_q      <= '0;
         hcnt_q       <= '0;
         pushed_q     <= 1'b0;
         pend_q       <= 1'b0;
         pend_q_entry <= '0;
         for (int i = 0; i < HOLD; i++) hold_q[i] <= '0;
      end else begin
         if (pend_q && !fifo_full) pend_q <= 1'b0;

         if (overflow) begin
            pend_q             <= 1'b1;
            pend_q_entry.first <= cand.first;
            pend_q_entry.stat  <= PS_OVERRUN;
            pend_q_entry.data  <= cand.data;
            open_q             <= 1'b0;
         end else if (ev_flag) begin
            if (!pend_q) open_q <= 1'b1;
            bitcnt_q <= '0;
            total_q  <= '0;
            hcnt_q   <= '0;
            pushed_q <= 1'b0;
            crc_q    <= CRC_INIT;
         end else if (ev_abort) begin
            open_q <= 1'b0;
         end else if (open_q && ev_data) begin
            sr_q     <= new_byte;
            bitcnt_q <= bitcnt_q + 3'd1;
            if (byte_done) begin
               crc_q <= crc16_octet(crc_q, new_byte, CRC_POLY_REV);
               if (total_q != TOT_SAT) total_q <= total_q + TW'(1);
               if (spill) begin
                  for (int i = 0; i < HOLD - 1; i++) hold_q[i] <= hold_q[i+1];
                  hold_q[HOLD-1] <= new_byte;
                  pushed_q       <= 1'b1;
               end else begin
                  for (int i = 0; i < HOLD; i++)
                     if (hcnt_q == HW'(i)) hold_q[i] <= new_byte;
                  hcnt_q <= hcnt_q + HW'(1);
               end
            end
         end
      end
   end

   // R6: while an overrun entry waits, the receiver stays out of any frame
   a_r6_pending_blocks_rx: assert property (@(posedge clk) disable iff (!rst_n)
      pend_q |-> !open_q);

   // R7: a too-short frame yields a single entry that opens its message
   a_r7_short_is_first: assert property (@(posedge clk) disable iff (!rst_n)
      (push && push_entry.stat == PS_SHORT) |-> push_entry.first);

   // R5: seven ones leave the frame
   a_r5_abort_leaves_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (open_q && ev_abort) |=> !open_q);

endmodule

// File: rtl/hdlc_rx_fifo.sv
module hdlc_rx_fifo
   import hdlc_rx_pkg::*;
#(
   parameter int DEPTH = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  rx_entry_t  wr_entry,
   input  logic       rd_en,
   output logic       full,
   output logic       empty,
   output logic       head_first,
   output logic [7:0] rd_data_o,
   output logic [2:0] rd_status_o
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);

   if (DEPTH < 2) begin : g_bad_depth
      $error("hdlc_rx_fifo: DEPTH must be at least 2");
   end

   rx_entry_t     mem_q [DEPTH];
   logic [PW-1:0] wptr_q, rptr_q, wptr_nxt, rptr_nxt;
   logic [CW-1:0] cnt_q;
   logic          do_wr, do_rd;

   if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
      assign wptr_nxt = wptr_q + PW'(1);
      assign rptr_nxt = rptr_q + PW'(1);
   end else begin : g_wrap
      assign wptr_nxt = (wptr_q == PW'(DEPTH - 1)) ? '0 : wptr_q + PW'(1);
      assign rptr_nxt = (rptr_q == PW'(DEPTH - 1)) ? '0 : rptr_q + PW'(1);
   end

   always_comb begin
      full       = (cnt_q == CNT_FULL);
      empty      = (cnt_q == '0);
      do_wr      = wr_en && !full;
      do_rd      = rd_en && !empty;
      head_first = !empty && mem_q[rptr_q].first;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q      <= '0;
         rptr_q      <= '0;
         cnt_q       <= '0;
         rd_data_o   <= '0;
         rd_status_o <= PS_BUSY;
         for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      end else begin
         if (do_wr) begin
            mem_q[wptr_q] <= wr_entry;
            wptr_q        <= wptr_nxt;
         end
         if (do_rd) begin
            rd_data_o   <= mem_q[rptr_q].data;
            rd_status_o <= mem_q[rptr_q].stat;
            rptr_q      <= rptr_nxt;
         end
         if (do_wr && !do_rd)      cnt_q <= cnt_q + CW'(1);
         else if (do_rd && !do_wr) cnt_q <= cnt_q - CW'(1);
      end
   end

   // R6: the assembler never offers an entry to a full FIFO
   a_r6_no_write_when_full: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !full);

   // R11: a read of an empty FIFO changes nothing the host sees
   a_r11_empty_read_inert: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && empty) |=> ($stable(rd_data_o) && $stable(rd_status_o)));

   // R9: occupancy stays within the storage
   a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_FULL);

endmodule

// File: rtl/hdlc_rx_status.sv
module hdlc_rx_status
   import hdlc_rx_pkg::*;
#(
   parameter int FIFO_DEPTH   = 4,
   parameter int MIN_OK_BYTES = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_valid,
   input  logic       bit_in,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic [2:0] rd_status,
   output logic       rd_empty,
   output logic       next_is_first
);
   logic      ev_flag, ev_abort, ev_data, data_bit;
   logic      fifo_full, push;
   rx_entry_t push_entry;

   hdlc_bit_front #(
      .FLAG_RUN  (6),
      .ABORT_RUN (7)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .bit_valid (bit_valid),
      .bit_in    (bit_in),
      .ev_flag   (ev_flag),
      .ev_abort  (ev_abort),
      .ev_data   (ev_data),
      .data_bit  (data_bit)
   );

   hdlc_frame_asm #(
      .FCS_BYTES    (2),
      .MIN_OK_BYTES (MIN_OK_BYTES)
   ) u_asm (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_flag    (ev_flag),
      .ev_abort   (ev_abort),
      .ev_data    (ev_data),
      .data_bit   (data_bit),
      .fifo_full  (fifo_full),
      .push       (push),
      .push_entry (push_entry)
   );

   hdlc_rx_fifo #(
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (push),
      .wr_entry    (push_entry),
      .rd_en       (rd_en),
      .full        (fifo_full),
      .empty       (rd_empty),
      .head_first  (next_is_first),
      .rd_data_o   (rd_data),
      .rd_status_o (rd_status)
   );

   // R10: a first-octet mark needs an octet waiting
   a_r10_first_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
      next_is_first |-> !rd_empty);

endmodule

// File: tb/sim_hdlc_rx_status.sv
module sim_hdlc_rx_status;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_valid = 1'b0;
   logic       bit_in = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic [2:0] rd_status;
   logic       rd_empty;
   logic       next_is_first;

   int checks = 0;
   int errors = 0;
   int ones_run = 0;
   int cycles = 0;
   bit done = 1'b0;
   logic [7:0] frm [0:15];
   logic [7:0] pat [0:5];

   always #10 clk = ~clk;

   hdlc_rx_status u0 (
      .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
      .rd_en(rd_en), .rd_data(rd_data), .rd_status(rd_status),
      .rd_empty(rd_empty), .next_is_first(next_is_first)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000 && !done) begin
         done = 1'b1;
         $display("FAIL watchdog: run hung (actual %0d cycles, expected fewer)", cycles);
         errors = errors + 1;
         $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks = checks + 1;
      if (!ok) begin
         errors = errors + 1;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic line_bit(input logic b);
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = b;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         bit_valid = 1'b0;
      end
   endtask

   task automatic send_flag();
      for (int i = 0; i < 8; i++) line_bit(((8'h7E >> i) & 1) != 0);
      ones_run = 0;
   endtask

   task automatic send_ones(input int n);
      for (int i = 0; i < n; i++) line_bit(1'b1);
   endtask

   task automatic send_octet(input logic [7:0] v);
      for (int i = 0; i < 8; i++) begin
         line_bit(v[i]);
         if (v[i]) ones_run = ones_run + 1; else ones_run = 0;
         if (ones_run == 5) begin
            line_bit(1'b0);
            ones_run = 0;
         end
      end
   endtask

   function automatic logic [15:0] fcs_of(input int len);
      logic [15:0] c = 16'hFFFF;
      for (int k = 0; k < len; k++)
         for (int i = 0; i < 8; i++)
            if (c[0] ^ frm[k][i]) c = (c >> 1) ^ 16'h8408;
            else                  c = c >> 1;
      return ~c;
   endfunction

   task automatic send_frame(input int len, input bit corrupt);
      logic [15:0] f;
      f = fcs_of(len);
      if (corrupt) f[0] = ~f[0];
      send_flag();
      for (int k = 0; k < len; k++) send_octet(frm[k]);
      send_octet(f[7:0]);
      send_octet(f[15:8]);
      send_flag();
      idle(4);
   endtask

   task automatic read_chk(input logic [7:0] ed, input logic [2:0] es,
                           input logic ef, input string req);
      @(negedge clk);
      chk(next_is_first == ef, {req, " first-octet mark"}, next_is_first, ef);
      rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      chk(rd_data == ed, {req, " data"}, rd_data, ed);
      chk(rd_status == es, {req, " status"}, rd_status, es);
   endtask

   task automatic empty_chk(input logic e, input string req);
      @(negedge clk);
      chk(rd_empty == e, {req, " empty"}, rd_empty, e);
   endtask

   initial begin
      pat[0] = 8'h7E; pat[1] = 8'hFF; pat[2] = 8'h3F;
      pat[3] = 8'hA5; pat[4] = 8'h00; pat[5] = 8'hF8;
      idle(3);
      // R8 R9 R10: reset state
      chk(rd_empty == 1'b1, "R9 reset empty", rd_empty, 1);
      chk(rd_status == 3'b000, "R8 reset status", rd_status, 0);
      chk(next_is_first == 1'b0, "R10 reset first", next_is_first, 0);
      rst_n = 1'b1;
      idle(2);

      // R1: flags and idle ones store nothing
      send_flag(); send_flag(); send_flag();
      send_ones(10);
      send_flag(); send_flag();
      idle(4);
      empty_chk(1'b1, "R1 flags/idle");

      // R2 R3 R8 R10: good frames over several lengths
      for (int len = 2; len <= 4; len++) begin
         for (int k = 0; k < len; k++) frm[k] = pat[(k * 3 + len) % 6];
         send_frame(len, 1'b0);
         for (int k = 0; k < len; k++)
            read_chk(frm[k], (k == len - 1) ? 3'b001 : 3'b000, k == 0,
                     (k == len - 1) ? "R3 good end" : "R2 R8 payload");
         empty_chk(1'b1, "R9 drained");
      end

      // R11: read while empty holds last octet and code
      @(negedge clk); rd_en = 1'b1;
      @(negedge clk); rd_en = 1'b0;
      chk(rd_status == 3'b001, "R11 status held", rd_status, 1);
      chk(rd_data == frm[3], "R11 data held", rd_data, frm[3]);

      // R4: corrupted check octet
      frm[0] = 8'h12; frm[1] = 8'h7E; frm[2] = 8'hC3;
      send_frame(3, 1'b1);
      read_chk(8'h12, 3'b000, 1'b1, "R4 payload");
      read_chk(8'h7E, 3'b000, 1'b0, "R4 payload");
      read_chk(8'hC3, 3'b010, 1'b0, "R4 bad crc end");

      // R7: one payload octet plus check octets is three octets
      frm[0] = 8'h5A;
      send_frame(1, 1'b0);
      read_chk(8'h5A, 3'b101, 1'b1, "R7 three-octet frame");
      empty_chk(1'b1, "R7 single entry");
      // R7: two raw octets between flags
      send_flag(); send_octet(8'h11); send_octet(8'h22); send_flag(); idle(4);
      read_chk(8'h11, 3'b101, 1'b1, "R7 two-octet frame");
      empty_chk(1'b1, "R7 single entry");

      // R5: abort after five octets
      send_flag();
      for (int k = 0; k < 5; k++) send_octet(8'h10 + 8'(k));
      send_ones(7);
      idle(4);
      read_chk(8'h10, 3'b000, 1'b1, "R5 payload");
      read_chk(8'h11, 3'b000, 1'b0, "R5 payload");
      read_chk(8'h12, 3'b011, 1'b0, "R5 abort end");
      empty_chk(1'b1, "R5 single end entry");

      // R6: eight-octet frame into a four-entry FIFO
      for (int k = 0; k < 8; k++) frm[k] = 8'h20 + 8'(k);
      send_frame(8, 1'b0);
      for (int k = 0; k < 4; k++) read_chk(frm[k], 3'b000, k == 0, "R6 stored");
      idle(2);
      read_chk(8'h24, 3'b100, 1'b0, "R6 overrun end");
      empty_chk(1'b1, "R6 rest dropped");
      // R6: reception resumes at the next flag
      frm[0] = 8'hE7; frm[1] = 8'h01;
      send_frame(2, 1'b0);
      read_chk(8'hE7, 3'b000, 1'b1, "R6 resume");
      read_chk(8'h01, 3'b001, 1'b0, "R6 resume end");
      empty_chk(1'b1, "R9 final");

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule